// File: doc/BRIEF.md
# Tagged Translation Buffer with Access-Right Check

This block caches virtual-to-physical page translations for a 32-bit virtual address space that uses 4 KiB pages. Each lookup request carries a virtual address, an address-space identifier and an access kind. The request is registered, and the lookup then runs on the registered copy. The low 12 bits of the address are the page offset. The upper 20 bits are the virtual page number. Every valid entry is compared against the page number and the identifier in parallel, and any entry may hold any page.

A translation that is found and permits the access is reported as a hit, with the physical page joined to the untouched offset. A translation that is found but denies the access is reported as a fault. When no entry matches, the result is a miss. An external miss handler walks the page table and installs entries through a fill port. The identifier tag lets translations from several processes live side by side, so a context switch needs no invalidation. When one is wanted anyway, a flush input drops every entry in one cycle.

Top module: `tlb_tagged`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss, and the replacement pointer starts at entry 0.
- R2: A request presented before clock edge N is judged after edge N. If a valid entry holds the same page number (address bits 31..12) and identifier and permits the access, hit_o is 1 and paddr_o is the entry's physical page followed by address bits 11..0 unchanged.
- R3: An entry matches only when its identifier equals the request's identifier. Entries with the same page number and different identifiers coexist and each returns its own physical page.
- R4: A load (req_store_i=0) to an entry whose read right is 0, or a store (req_store_i=1) to an entry whose write right is 0, sets fault_o=1 and leaves hit_o=0.
- R5: hit_o, miss_o and fault_o are mutually exclusive, and all three are 0 in a cycle with no registered request.
- R6: flush_i invalidates every entry at the next edge. A fill presented in the same cycle as a flush is dropped.
- R7: A fill that matches no valid entry goes into the lowest-numbered invalid entry when one exists.
- R8: When all entries are valid, a new fill replaces the entry at the round-robin pointer. The pointer advances by one, modulo the entry count, on every accepted fill.
- R9: A fill whose page number and identifier equal those of a valid entry overwrites that entry, so no two valid entries ever match the same request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_asid_i | input | 8 | Address-space identifier of the requester |
| req_store_i | input | 1 | 1 for a store, 0 for a load |
| hit_o | output | 1 | Translation found and access permitted |
| miss_o | output | 1 | No matching entry |
| fault_o | output | 1 | Translation found but access denied |
| paddr_o | output | 32 | Physical address, valid with hit_o, else 0 |
| fill_valid_i | input | 1 | Install an entry this cycle |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_asid_i | input | 8 | Identifier for the installed entry |
| fill_ppn_i | input | 20 | Physical page number to install |
| fill_rd_i | input | 1 | Read right of the installed entry |
| fill_wr_i | input | 1 | Write right of the installed entry |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The bench targets the following corner cases, and each one catches a specific class of wrong design:

- **Identifier aliasing.** The same page is installed under two identifiers. A design that ignored the tag would return the wrong physical page.
- **Rights denial.** Read-only and write-only pages are used. Swapped or missing rights show up as hits where faults are expected.
- **Refill of a present page.** A design that allocated a new slot instead of overwriting would leave a stale duplicate.
- **Flush together with a fill.** A design that let the fill survive the flush would still hit afterwards.
- **Overflow past sixteen pages.** A wrong pointer or free-slot choice evicts the wrong page, and later lookups expose it.

A long random mix of fills, flushes and lookups over a small pool of pages and identifiers is compared against a reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // access right test for one entry
  function automatic logic access_ok(input logic is_store, input logic rd, input logic wr);
    return is_store ? wr : rd;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ENTRIES-1:0]               valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_tab_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0]   asid_tab_i,
  input  logic [VPN_W-1:0]                 key_vpn_i,
  input  logic [ASID_W-1:0]                key_asid_i,
  output logic [ENTRIES-1:0]               match_o,
  output logic                             any_o,
  output logic [IDX_W-1:0]                 idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_tab_i[g] == key_vpn_i)
                        && (asid_tab_i[g] == key_asid_i);
  end

  assign any_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

  AST_NO_DUP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o)); // R9
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               dup_i,
  input  logic [IDX_W-1:0]   dup_idx_i,
  input  logic               adv_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  // duplicate first, then lowest free slot, then round robin
  always_comb begin
    if (dup_i)         idx_o = dup_idx_i;
    else if (free_any) idx_o = free_idx;
    else               idx_o = rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rr_q <= '0;
    else if (adv_i) rr_q <= rr_q + 1'b1;
  end

  AST_RR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> rr_q == IDX_W'($past(rr_q) + 1'b1)); // R8
  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(rr_q)); // R8
  AST_FREE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dup_i && free_any) |-> !valid_i[idx_o]); // R7
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned ASID_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      req_vaddr_i,
  input  logic [ASID_W-1:0]    req_asid_i,
  input  logic                 req_store_i,
  output logic                 hit_o,
  output logic                 miss_o,
  output logic                 fault_o,
  output logic [PA_W-1:0]      paddr_o,
  input  logic                 fill_valid_i,
  input  logic [VA_W-PAGE_W-1:0] fill_vpn_i,
  input  logic [ASID_W-1:0]    fill_asid_i,
  input  logic [PA_W-PAGE_W-1:0] fill_ppn_i,
  input  logic                 fill_rd_i,
  input  logic                 fill_wr_i,
  input  logic                 flush_i
);
  import tlb_pkg::*;

  localparam int unsigned VPN_W = VA_W - PAGE_W;
  localparam int unsigned PPN_W = PA_W - PAGE_W;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  // registered request
  logic              req_valid_q, req_store_q;
  logic [VA_W-1:0]   req_vaddr_q;
  logic [ASID_W-1:0] req_asid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_q <= 1'b0;
      req_store_q <= 1'b0;
      req_vaddr_q <= '0;
      req_asid_q  <= '0;
    end else begin
      req_valid_q <= req_valid_i;
      req_store_q <= req_store_i;
      req_vaddr_q <= req_vaddr_i;
      req_asid_q  <= req_asid_i;
    end
  end

  // entry storage
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0]             rd_q, wr_q;

  logic             fill_go;
  logic [IDX_W-1:0] fill_idx;
  logic [ENTRIES-1:0] fill_match;
  logic             fill_dup;
  logic [IDX_W-1:0] fill_dup_idx;

  assign fill_go = fill_valid_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (fill_go) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_go) begin
      vpn_q[fill_idx]  <= fill_vpn_i;
      asid_q[fill_idx] <= fill_asid_i;
      ppn_q[fill_idx]  <= fill_ppn_i;
      rd_q[fill_idx]   <= fill_rd_i;
      wr_q[fill_idx]   <= fill_wr_i;
    end
  end

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_fill_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_q),
    .vpn_tab_i  (vpn_q),
    .asid_tab_i (asid_q),
    .key_vpn_i  (fill_vpn_i),
    .key_asid_i (fill_asid_i),
    .match_o    (fill_match),
    .any_o      (fill_dup),
    .idx_o      (fill_dup_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_q),
    .dup_i     (fill_dup),
    .dup_idx_i (fill_dup_idx),
    .adv_i     (fill_go),
    .idx_o     (fill_idx)
  );

  // lookup on registered request
  logic [ENTRIES-1:0] look_match;
  logic               look_any;
  logic [IDX_W-1:0]   look_idx;
  logic               perm_ok;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_look_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_q),
    .vpn_tab_i  (vpn_q),
    .asid_tab_i (asid_q),
    .key_vpn_i  (req_vaddr_q[VA_W-1:PAGE_W]),
    .key_asid_i (req_asid_q),
    .match_o    (look_match),
    .any_o      (look_any),
    .idx_o      (look_idx)
  );

  assign perm_ok = access_ok(req_store_q, rd_q[look_idx], wr_q[look_idx]);
  assign hit_o   = req_valid_q && look_any && perm_ok;
  assign fault_o = req_valid_q && look_any && !perm_ok;
  assign miss_o  = req_valid_q && !look_any;
  assign paddr_o = hit_o ? {ppn_q[look_idx], req_vaddr_q[PAGE_W-1:0]} : '0;

  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, fault_o})); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_q |-> !(hit_o || miss_o || fault_o)); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0); // R6
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |=> valid_q != '0); // R7
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[PAGE_W-1:0] == req_vaddr_q[PAGE_W-1:0]); // R2
  AST_FAULT_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (look_match != '0)); // R4
endmodule

// File: tb/tlb_tagged_bench.sv
module tlb_tagged_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic        hit, miss, fault;
  logic [31:0] paddr;
  logic        fill_valid = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, flush = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [7:0]  fill_asid = '0;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  tlb_tagged u_tlb_tagged (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_asid_i(req_asid), .req_store_i(req_store),
    .hit_o(hit), .miss_o(miss), .fault_o(fault), .paddr_o(paddr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid), .fill_ppn_i(fill_ppn),
    .fill_rd_i(fill_rd), .fill_wr_i(fill_wr), .flush_i(flush)
  );

  // reference model
  logic        m_v [16];
  logic [19:0] m_vpn [16];
  logic [7:0]  m_asid [16];
  logic [19:0] m_ppn [16];
  logic        m_r [16];
  logic        m_w [16];
  int          m_rr = 0;

  function automatic int m_find(logic [19:0] vpn, logic [7:0] asid);
    for (int i = 0; i < 16; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  function automatic void m_flush();
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
  endfunction

  function automatic void m_fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn, logic r, logic w);
    int idx = m_find(vpn, asid);
    if (idx < 0)
      for (int i = 15; i >= 0; i--) if (!m_v[i]) idx = i;
    if (idx < 0) idx = m_rr;
    m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_asid[idx] = asid;
    m_ppn[idx] = ppn; m_r[idx] = r; m_w[idx] = w;
    m_rr = (m_rr + 1) % 16;
  endfunction

  task automatic check(bit ok, string tag, string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic do_fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn, logic r, logic w, bit with_flush);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn;
    fill_rd = r; fill_wr = w; flush = with_flush;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
    if (with_flush) m_flush();
    else m_fill(vpn, asid, ppn, r, w);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_flush();
  endtask

  task automatic lookup(logic [19:0] vpn, logic [11:0] off, logic [7:0] asid, logic st, string tag);
    int idx;
    logic eh, em, ef;
    logic [31:0] ep;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {vpn, off}; req_asid = asid; req_store = st;
    @(negedge clk);
    idx = m_find(vpn, asid);
    em = (idx < 0);
    eh = !em && (st ? m_w[idx] : m_r[idx]);
    ef = !em && !eh;
    ep = eh ? {m_ppn[idx], off} : 32'h0;
    check(hit == eh && miss == em && fault == ef && paddr == ep, tag,
          $sformatf("act h/m/f=%b%b%b pa=%h exp h/m/f=%b%b%b pa=%h",
                    hit, miss, fault, paddr, eh, em, ef, ep));
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd375));
    m_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    lookup(20'h00001, 12'h123, 8'd1, 1'b0, "R1");
    lookup(20'h00000, 12'h000, 8'd0, 1'b1, "R1");

    // R5: idle cycle quiet
    @(negedge clk);
    check(!hit && !miss && !fault, "R5",
          $sformatf("act h/m/f=%b%b%b exp 000", hit, miss, fault));

    // R2: basic translation, offset passes
    do_fill(20'hABCDE, 8'd1, 20'h12345, 1'b1, 1'b1, 1'b0);
    lookup(20'hABCDE, 12'hFFF, 8'd1, 1'b0, "R2");
    lookup(20'hABCDE, 12'h001, 8'd1, 1'b1, "R2");

    // R3: identifier tagging
    lookup(20'hABCDE, 12'h010, 8'd2, 1'b0, "R3");
    do_fill(20'hABCDE, 8'd2, 20'h0BEEF, 1'b1, 1'b0, 1'b0);
    lookup(20'hABCDE, 12'h020, 8'd2, 1'b0, "R3");
    lookup(20'hABCDE, 12'h030, 8'd1, 1'b0, "R3");

    // R4: rights
    lookup(20'hABCDE, 12'h040, 8'd2, 1'b1, "R4");
    do_fill(20'h00777, 8'd1, 20'h55555, 1'b0, 1'b1, 1'b0);
    lookup(20'h00777, 12'h050, 8'd1, 1'b0, "R4");
    lookup(20'h00777, 12'h060, 8'd1, 1'b1, "R4");

    // R9: refill overwrites
    do_fill(20'hABCDE, 8'd1, 20'h0CAFE, 1'b0, 1'b1, 1'b0);
    lookup(20'hABCDE, 12'h070, 8'd1, 1'b1, "R9");
    lookup(20'hABCDE, 12'h080, 8'd1, 1'b0, "R9");

    // R6: flush wins over a same-cycle fill
    do_fill(20'h00999, 8'd3, 20'h11111, 1'b1, 1'b1, 1'b1);
    lookup(20'h00999, 12'h090, 8'd3, 1'b0, "R6");
    lookup(20'hABCDE, 12'h0A0, 8'd2, 1'b0, "R6");
    lookup(20'h00777, 12'h0B0, 8'd1, 1'b1, "R6");

    // R7: fills land in free slots
    for (int k = 0; k < 3; k++) do_fill(20'(k + 32'h200), 8'd4, 20'(k + 32'h300), 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) lookup(20'(k + 32'h200), 12'h0C0, 8'd4, 1'b0, "R7");

    // R8: overflow evicts at round-robin pointer
    do_flush();
    for (int k = 0; k < 17; k++) do_fill(20'(k + 32'h400), 8'd5, 20'(k + 32'h500), 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 17; k++) lookup(20'(k + 32'h400), 12'h0D0, 8'd5, 1'b0, "R8");
    do_fill(20'h00500, 8'd5, 20'h0AAAA, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 17; k++) lookup(20'(k + 32'h400), 12'h0E0, 8'd5, 1'b1, "R8");

    // random mix over a small pool
    for (int n = 0; n < 800; n++) begin
      int op = $urandom_range(0, 99);
      logic [19:0] vpn = 20'($urandom_range(0, 23) * 37 + 5);
      logic [7:0]  asid = 8'($urandom_range(0, 3));
      if (op < 30)
        do_fill(vpn, asid, 20'($urandom), 1'($urandom), 1'($urandom), 1'b0);
      else if (op < 32)
        do_flush();
      else
        lookup(vpn, 12'($urandom), asid, 1'($urandom), "R2/R4 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule